// File: doc/BRIEF.md
# Network Device Power State Controller

This block holds and enforces the device power state of a network controller that sits on a host bus. The host selects one of four states through a two-bit request written into a power-management register. Full power is split into two substates. The uninitialized substate is entered after reset, and the active substate is entered once the host programs an address register. In the uninitialized substate the device answers configuration accesses only. Bus mastering and interrupts are allowed only in the active full-power substate.

In the intermediate state D2, a down link together with a set low-power enable puts the block into a deep-saving substate. There link keepalive transmission stops and the block waits for the link to come back. Wake sources are an already-decoded wake-packet pulse and any change of the link level. When wake is permitted in the current state, a wake source sets a sticky event flag. That flag drives the active-low event output and is cleared only by a host write-one-to-clear strobe. In D3, wake is available only while auxiliary power is present.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset the state is D0 (code 00), `d0_active` is 0, `master_en` and `irq_en` are 0, `keepalive_en` is 1, `deep_save` is 0 and `pme_n` is 1.
- R2: A pulse on any bit of `bar_init` while in D0 with `d0_active`=0, and with no `req_wr` in the same cycle, sets `d0_active` on the next cycle. In any other state the strobe is ignored.
- R3: `master_en` and `irq_en` are high only when the state is D0 and `d0_active` is 1.
- R4: `req_wr` loads `req_state` into the state on the next cycle, with the codes 00=D0, 01=D1, 10=D2, 11=D3. A request for D0 from any other state returns the block to the uninitialized substate. A request for D0 while already in D0 keeps the substate.
- R5: A wake source is a `wake_pkt` pulse or a change of the `link_up` level. A wake source seen in D0 with `d0_active`=0, in D1 or in D2 drives `pme_n` low on the next cycle. The same source is ignored in D0 with `d0_active`=1.
- R6: In D3 a wake source drives `pme_n` low only while `aux_pwr` is 1. `keepalive_en` is low in D3 while `aux_pwr` is 0.
- R7: In D2, with `link_up`=0 and `lowpwr_en`=1 and no `req_wr`, `deep_save` rises on the next cycle and `keepalive_en` falls with it.
- R8: With `lowpwr_en`=0, `deep_save` never rises.
- R9: While `deep_save` is 1, `link_up`=1 clears `deep_save` and restores `keepalive_en` on the next cycle, and it drives `pme_n` low.
- R10: `pme_n` stays low until a `pme_clr` pulse, and it rises on the cycle after that pulse. A state change does not release it. A wake source in the same cycle as `pme_clr` keeps it low.
- R11: Any `req_wr` clears `deep_save` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low bus reset |
| req_wr | input | 1 | Host write strobe for the requested state |
| req_state | input | 2 | Requested state code |
| bar_init | input | NUM_BAR | Address register programming strobes, one per register |
| link_up | input | 1 | Link valid level |
| wake_pkt | input | 1 | Decoded wake packet pulse |
| aux_pwr | input | 1 | Auxiliary power present |
| lowpwr_en | input | 1 | Enable for the deep-saving substate in D2 |
| pme_clr | input | 1 | Write-one-to-clear strobe for the wake event flag |
| pstate | output | 2 | Current state code |
| d0_active | output | 1 | Full-power substate: 1 = active, 0 = uninitialized |
| master_en | output | 1 | Bus-master activity permitted |
| irq_en | output | 1 | Interrupts permitted |
| keepalive_en | output | 1 | Idle symbols and link pulses permitted |
| deep_save | output | 1 | Deep-saving substate of D2 |
| pme_n | output | 1 | Active-low power-management event |

## Verification
The assertions check on every cycle that the master and interrupt gates are open only in D0, that the deep substate lives only in D2 with keepalive off and rises only when enabled on a down link, that the event output is sticky until cleared, that it cannot be raised in D3 without auxiliary power, and that an address strobe activates the uninitialized substate. Only the bench's scenarios can show the whole paths across states. These include a return to the uninitialized substate from D1, wake handling in each state, the exit from the deep substate on link recovery, a deep substate cut short by a state request, and a clear that collides with a new wake. The bench checks them against its own cycle model.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pstate_e;
endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_wr,
  input  pstate_e   req_state,
  input  logic      bar_hit,
  input  logic      link_up,
  input  logic      lowpwr_en,
  output pstate_e   st,
  output logic      d0a,
  output logic      deep,
  output logic      deep_exit
);
  pstate_e st_nxt;
  logic    d0a_nxt;
  logic    deep_nxt;
  logic    st_en;

  // next-state process
  always_comb begin
    st_en    = req_wr;
    st_nxt   = req_wr ? req_state : st;
    d0a_nxt  = d0a;
    deep_nxt = deep;
    if (req_wr) begin
      // host request wins over every local event in this cycle
      deep_nxt = 1'b0;
      if (req_state == PS_D0 && st != PS_D0) d0a_nxt = 1'b0;
    end else begin
      if (st == PS_D0 && !d0a && bar_hit) d0a_nxt = 1'b1;
      if (st == PS_D2) begin
        if (deep && link_up)                        deep_nxt = 1'b0;
        else if (!deep && !link_up && lowpwr_en)    deep_nxt = 1'b1;
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= PS_D0;
      d0a  <= 1'b0;
      deep <= 1'b0;
    end else begin
      if (st_en) st <= st_nxt;
      d0a  <= d0a_nxt;
      deep <= deep_nxt;
    end
  end

  assign deep_exit = deep && link_up;
endmodule

// File: rtl/pwr_wake_unit.sv
module pwr_wake_unit
  import pwr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pstate_e st,
  input  logic    d0a,
  input  logic    aux_pwr,
  input  logic    link_up,
  input  logic    wake_pkt,
  input  logic    deep_exit,
  input  logic    pme_clr,
  output logic    pme_flag
);
  logic link_q;
  logic wake_ok;
  logic link_chg;
  logic wake_set;
  logic pme_nxt;

  always_comb begin
    unique case (st)
      PS_D0:   wake_ok = !d0a;
      PS_D1:   wake_ok = 1'b1;
      PS_D2:   wake_ok = 1'b1;
      PS_D3:   wake_ok = aux_pwr;
      default: wake_ok = 1'b0;
    endcase
    link_chg = link_up ^ link_q;
    wake_set = wake_ok && (wake_pkt || link_chg || deep_exit);
    // a new event outranks a clear in the same cycle
    if (wake_set)     pme_nxt = 1'b1;
    else if (pme_clr) pme_nxt = 1'b0;
    else              pme_nxt = pme_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q   <= 1'b0;
      pme_flag <= 1'b0;
    end else begin
      link_q   <= link_up;
      pme_flag <= pme_nxt;
    end
  end
endmodule

// File: rtl/pwr_gate_dec.sv
module pwr_gate_dec
  import pwr_pkg::*;
(
  input  pstate_e st,
  input  logic    d0a,
  input  logic    deep,
  input  logic    aux_pwr,
  output logic    master_en,
  output logic    irq_en,
  output logic    keepalive_en
);
  logic full_on;

  always_comb begin
    full_on      = (st == PS_D0) && d0a;
    master_en    = full_on;
    irq_en       = full_on;
    keepalive_en = !deep && !((st == PS_D3) && !aux_pwr);
  end
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_pkg::*;
#(
  parameter int NUM_BAR   = 3,
  parameter int RST_STAGE = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_wr,
  input  logic [1:0]         req_state,
  input  logic [NUM_BAR-1:0] bar_init,
  input  logic               link_up,
  input  logic               wake_pkt,
  input  logic               aux_pwr,
  input  logic               lowpwr_en,
  input  logic               pme_clr,
  output logic [1:0]         pstate,
  output logic               d0_active,
  output logic               master_en,
  output logic               irq_en,
  output logic               keepalive_en,
  output logic               deep_save,
  output logic               pme_n
);
  logic    rst_n_s;
  pstate_e st;
  logic    d0a;
  logic    deep;
  logic    deep_exit;
  logic    pme_flag;

  pwr_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  pwr_state_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_s), .req_wr(req_wr),
    .req_state(pstate_e'(req_state)), .bar_hit(|bar_init),
    .link_up(link_up), .lowpwr_en(lowpwr_en),
    .st(st), .d0a(d0a), .deep(deep), .deep_exit(deep_exit)
  );

  pwr_wake_unit u_wake (
    .clk(clk), .rst_n(rst_n_s), .st(st), .d0a(d0a), .aux_pwr(aux_pwr),
    .link_up(link_up), .wake_pkt(wake_pkt), .deep_exit(deep_exit),
    .pme_clr(pme_clr), .pme_flag(pme_flag)
  );

  pwr_gate_dec u_gate (
    .st(st), .d0a(d0a), .deep(deep), .aux_pwr(aux_pwr),
    .master_en(master_en), .irq_en(irq_en), .keepalive_en(keepalive_en)
  );

  assign pstate    = st;
  assign d0_active = d0a;
  assign deep_save = deep;
  assign pme_n     = ~pme_flag;
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk #(
  parameter int NUM_BAR = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_wr,
  input logic [NUM_BAR-1:0] bar_init,
  input logic               link_up,
  input logic               aux_pwr,
  input logic               lowpwr_en,
  input logic               pme_clr,
  input logic [1:0]         pstate,
  input logic               d0_active,
  input logic               master_en,
  input logic               irq_en,
  input logic               keepalive_en,
  input logic               deep_save,
  input logic               pme_n
);
  a_r3_master_only_d0: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en || irq_en) |-> (pstate == 2'b00 && d0_active));

  a_r7_deep_in_d2: assert property (@(posedge clk) disable iff (!rst_n)
    deep_save |-> (pstate == 2'b10 && !keepalive_en));

  a_r8_deep_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deep_save) |-> ($past(lowpwr_en) && !$past(link_up) && $past(pstate) == 2'b10));

  a_r10_pme_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!pme_n && !pme_clr) |=> !pme_n);

  a_r6_d3_no_aux: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'b11 && !aux_pwr && pme_n) |=> pme_n);

  a_r2_bar_activates: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'b00 && !d0_active && (|bar_init) && !req_wr) |=> d0_active);
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk #(.NUM_BAR(NUM_BAR)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .bar_init(bar_init),
  .link_up(link_up), .aux_pwr(aux_pwr), .lowpwr_en(lowpwr_en),
  .pme_clr(pme_clr), .pstate(pstate), .d0_active(d0_active),
  .master_en(master_en), .irq_en(irq_en), .keepalive_en(keepalive_en),
  .deep_save(deep_save), .pme_n(pme_n)
);

// File: tb/pwr_state_ctrl_bench.sv
module pwr_state_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_wr = 1'b0;
  logic [1:0] req_state = 2'b00;
  logic [NB-1:0] bar_init = '0;
  logic link_up = 1'b0, wake_pkt = 1'b0, aux_pwr = 1'b0;
  logic lowpwr_en = 1'b0, pme_clr = 1'b0;
  logic [1:0] pstate;
  logic d0_active, master_en, irq_en, keepalive_en, deep_save, pme_n;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_state_ctrl #(.NUM_BAR(NB)) u_pwr_state_ctrl (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_state(req_state),
    .bar_init(bar_init), .link_up(link_up), .wake_pkt(wake_pkt),
    .aux_pwr(aux_pwr), .lowpwr_en(lowpwr_en), .pme_clr(pme_clr),
    .pstate(pstate), .d0_active(d0_active), .master_en(master_en),
    .irq_en(irq_en), .keepalive_en(keepalive_en), .deep_save(deep_save),
    .pme_n(pme_n)
  );

  // reference model
  int  m_st;
  bit  m_act, m_deep, m_lprev, m_pme;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_act = 0; m_deep = 0; m_lprev = 0; m_pme = 0;
    end else begin
      bit may_wake, ev;
      may_wake = (m_st == 0 && !m_act) || m_st == 1 || m_st == 2 ||
                 (m_st == 3 && aux_pwr);
      ev = wake_pkt || (link_up != m_lprev) || (m_deep && link_up);
      if (may_wake && ev) m_pme = 1;
      else if (pme_clr)   m_pme = 0;
      if (req_wr) begin
        if (req_state == 0 && m_st != 0) m_act = 0;
        m_st = int'(req_state);
        m_deep = 0;
      end else begin
        if (m_st == 0 && !m_act && bar_init != 0) m_act = 1;
        if (m_st == 2 && m_deep && link_up) m_deep = 0;
        else if (m_st == 2 && !m_deep && !link_up && lowpwr_en) m_deep = 1;
      end
      m_lprev = link_up;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R4 pstate", int'(pstate), m_st);
      chk("R2 d0_active", int'(d0_active), int'(m_act));
      chk("R3 master_en", int'(master_en), int'(m_st == 0 && m_act));
      chk("R3 irq_en", int'(irq_en), int'(m_st == 0 && m_act));
      chk("R7 keepalive_en", int'(keepalive_en),
          int'(!m_deep && !(m_st == 3 && !aux_pwr)));
      chk("R7 deep_save", int'(deep_save), int'(m_deep));
      chk("R5 pme_n", int'(pme_n), int'(!m_pme));
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse_wake();
    wake_pkt = 1; tick(); wake_pkt = 0;
  endtask
  task automatic pulse_clr();
    pme_clr = 1; tick(); pme_clr = 0;
  endtask
  task automatic request(input logic [1:0] s);
    req_state = s; req_wr = 1; tick(); req_wr = 0;
  endtask
  task automatic pulse_bar(input int idx);
    bar_init[idx] = 1'b1; tick(); bar_init = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) tick();
    #1;
    chk("R1 reset pstate", int'(pstate), 0);
    chk("R1 reset d0_active", int'(d0_active), 0);
    chk("R1 reset master_en", int'(master_en), 0);
    chk("R1 reset keepalive", int'(keepalive_en), 1);
    chk("R1 reset pme_n", int'(pme_n), 1);

    // wake in D0u, then clear
    pulse_wake(); #1;
    chk("R5 wake in D0u", int'(pme_n), 0);
    tick(); #1;
    chk("R10 pme held", int'(pme_n), 0);
    pulse_clr(); #1;
    chk("R10 pme cleared", int'(pme_n), 1);

    // address strobe activates
    pulse_bar(1); #1;
    chk("R2 bar sets active", int'(d0_active), 1);
    chk("R3 master in D0a", int'(master_en), 1);
    pulse_wake(); #1;
    chk("R5 wake ignored in D0a", int'(pme_n), 1);

    // D1 then back to D0u
    request(2'b01); #1;
    chk("R3 master off in D1", int'(master_en), 0);
    pulse_bar(0); #1;
    pulse_wake(); #1;
    chk("R5 wake in D1", int'(pme_n), 0);
    request(2'b00); #1;
    chk("R4 D0 request gives D0u", int'(d0_active), 0);
    chk("R10 state change keeps pme", int'(pme_n), 0);
    pulse_clr();
    pulse_bar(2);
    request(2'b00); #1;
    chk("R4 D0 in D0 keeps active", int'(d0_active), 1);

    // D2 deep-saving
    request(2'b10);
    lowpwr_en = 1; tick(); #1;
    chk("R7 deep entered", int'(deep_save), 1);
    chk("R7 keepalive off", int'(keepalive_en), 0);
    link_up = 1; tick(); #1;
    chk("R9 deep left", int'(deep_save), 0);
    chk("R9 keepalive back", int'(keepalive_en), 1);
    chk("R9 link wake", int'(pme_n), 0);
    pulse_clr();

    // disabled deep
    lowpwr_en = 0; link_up = 0; tick();
    pulse_clr();
    repeat (4) tick(); #1;
    chk("R8 no deep when disabled", int'(deep_save), 0);
    lowpwr_en = 1; tick(); #1;
    chk("R7 deep after enable", int'(deep_save), 1);
    request(2'b11); #1;
    chk("R11 request clears deep", int'(deep_save), 0);
    lowpwr_en = 0;

    // D3 with and without aux power
    aux_pwr = 0; tick(); #1;
    chk("R6 keepalive off in D3 no aux", int'(keepalive_en), 0);
    pulse_wake(); #1;
    chk("R6 no wake without aux", int'(pme_n), 1);
    aux_pwr = 1; tick();
    pulse_wake(); #1;
    chk("R6 wake with aux", int'(pme_n), 0);
    pulse_clr(); #1;
    chk("R10 clear in D3", int'(pme_n), 1);
    wake_pkt = 1; pme_clr = 1; tick(); wake_pkt = 0; pme_clr = 0; #1;
    chk("R10 wake beats clear", int'(pme_n), 0);
    pulse_clr();

    repeat (3) tick();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule